// File: doc/BRIEF.md
# Stepper Driver Chain Serial Master

This block sends control words over a serial link to a daisy chain of one to three stepper motor driver chips. The link has three kinds of line: chip selects, a serial clock and a data line. A host sets a global configuration through a parallel register load. The configuration holds the chain length, a 7-bit clock divider, five polarity bits and a flag that picks either one common select or one select per driver.

When the host pulses `start`, the block captures one 12-bit word per driver and applies the phase, fast-decay and DAC polarities to each word. It then shifts the whole frame out, most significant bit first, beginning with the driver farthest down the chain. `busy` stays high from the first half period of the frame to the end of the gap after it.

The serial clock runs at the system clock divided by 2×(d+1), with a 50% duty cycle. Here d is the programmed divider, raised to a floor of 7 when it is smaller.

Top module: `stepchain_master`

## Requirements
- R1: The chain length field `cfg_len` selects the number of driver words per frame: 0 gives one, 1 gives two, 2 gives three, and 3 is treated as three. A frame carries 12 bits per driver.
- R2: Each serial clock period lasts 2×(d+1) system cycles, where d is the effective divider. The clock is in its active-high phase for exactly d+1 of those cycles.
- R3: A divider value below 7 behaves exactly as 7, in both the clock timing and the frame length.
- R4: With `cfg_pol_sel`=0 an asserted select reads 0 and an idle select reads 1. With `cfg_pol_sel`=1 both levels are reversed.
- R5: The serial clock idles at the level of `cfg_pol_sck`. When that bit is 1, `sck_o` is the inverse of the default waveform, in which the clock idles low and data is sampled on the rising edge.
- R6: When `cfg_pol_ph`=1, the phase bits are sent inverted. These are bits 11 and 5 of every word, where word layout is {phA, fdA, dacA[3:0], phB, fdB, dacB[3:0]}.
- R7: When `cfg_pol_fd`=1, the fast-decay bits are sent inverted. These are bits 10 and 4 of every word.
- R8: When `cfg_pol_dac`=1, the DAC fields are sent inverted. These are bits 9:6 and 3:0 of every word.
- R9: Words are sent MSB first, starting with the word of driver `cfg_len` and ending with driver 0. Data changes only on falling edges of the default clock and is stable at every rising edge.
- R10: With `cfg_indiv`=0, only `sel_o[0]` is asserted. It is asserted for 2N+1 half periods, where N is the number of bits: the data bits plus a trailing low half. The other select lines stay idle.
- R11: With `cfg_indiv`=1, the select of driver k is asserted only while that driver's 24 half periods are on the line. Driver 0, which is sent last, also keeps its select through the trailing half. Selects of drivers beyond the chain length stay idle, and at most one select is asserted at a time.
- R12: `busy` rises in the cycle after an accepted `start` and stays high for (2N+3)×(d+1) cycles. The last two of those half periods are a gap with all selects idle. A `start` while `busy` is high is ignored and is not queued.
- R13: A configuration write while `busy` is high is ignored. The next frame still uses the earlier settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the configuration inputs |
| cfg_len | input | 2 | Chain length code |
| cfg_div | input | 7 | Serial clock divider |
| cfg_pol_sel | input | 1 | Select polarity (1 = active high) |
| cfg_pol_sck | input | 1 | Serial clock inversion |
| cfg_pol_ph | input | 1 | Phase bit inversion |
| cfg_pol_fd | input | 1 | Fast-decay bit inversion |
| cfg_pol_dac | input | 1 | DAC field inversion |
| cfg_indiv | input | 1 | 0 = common select, 1 = one select per driver |
| start | input | 1 | Begin a frame |
| drv_words | input | NDRV*12 | Logical word per driver, driver k at bits [12k+11:12k] |
| busy | output | 1 | Frame in progress |
| sel_o | output | NDRV | Chip selects, polarity applied |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data |

## Verification
The bench sweeps every chain length code, including the unused code 3, in both select modes. It uses divider values below, at and above the floor of 7, and polarity sets that invert alternating fields, none, or all.

For each frame the bench checks the following:
- It rebuilds the expected bit stream arithmetically and compares each field class separately. A swapped word order or a wrong inversion mask shows up as a mismatch in the field it corrupts.
- It measures the clock high time and the frame length. A divider with no floor would shorten both, and an asymmetric divider would give a high time other than d+1.
- It counts the asserted cycles on each select line. A wrong window in individual mode, or a leaking select in common mode, changes these counts.
- It writes a new configuration and pulses `start` mid-frame. A design that honoured either would stretch the frame or use the new divider on the next one.

// File: rtl/stepchain_pkg.sv
package stepchain_pkg;
   localparam int WORD_W = 12;
   localparam int DIV_W  = 7;
   localparam int LEN_W  = 2;

   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic [DIV_W-1:0] div;
      logic             pol_sel;
      logic             pol_sck;
      logic             pol_ph;
      logic             pol_fd;
      logic             pol_dac;
      logic             indiv;
   } chain_cfg_t;
endpackage

// File: rtl/stepchain_divider.sv
module stepchain_divider #(
   parameter int DIV_W   = 7,
   parameter int DIV_MIN = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   if (DIV_MIN < 1 || DIV_MIN >= (1 << DIV_W)) begin : g_bad_min
      $error("DIV_MIN out of range");
   end

   localparam logic [DIV_W-1:0] MIN_V = DIV_W'(DIV_MIN);

   logic [DIV_W-1:0] d_eff;
   logic [DIV_W-1:0] cnt;

   assign d_eff = (div < MIN_V) ? MIN_V : div;
   assign tick  = run && (cnt == d_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt >= d_eff) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   // R2
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R3
   cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt == '0 && $past(run)) |-> $past(cnt) >= MIN_V);
endmodule

// File: rtl/stepchain_fmt.sv
module stepchain_fmt
   import stepchain_pkg::*;
#(
   parameter int NDRV = 3
) (
   input  logic [NDRV*WORD_W-1:0] words,
   input  logic [1:0]             len_c,
   input  logic                   pol_ph,
   input  logic                   pol_fd,
   input  logic                   pol_dac,
   output logic [NDRV*WORD_W-1:0] frame_bits
);
   localparam int TOT = NDRV * WORD_W;

   logic [WORD_W-1:0] fw [NDRV];

   for (genvar k = 0; k < NDRV; k++) begin : g_drv
      logic [WORD_W-1:0] w;
      assign w = words[k*WORD_W +: WORD_W];
      assign fw[k] = {w[11] ^ pol_ph, w[10] ^ pol_fd, w[9:6] ^ {4{pol_dac}},
                      w[5]  ^ pol_ph, w[4]  ^ pol_fd, w[3:0] ^ {4{pol_dac}}};
   end

   always_comb begin
      frame_bits = '0;
      for (int j = 0; j < NDRV; j++) begin
         if (j <= int'(len_c))
            frame_bits[TOT-1-j*WORD_W -: WORD_W] = fw[int'(len_c) - j];
      end
   end
endmodule

// File: rtl/stepchain_selgen.sv
module stepchain_selgen
   import stepchain_pkg::*;
#(
   parameter int NDRV   = 3,
   parameter int HALF_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              indiv,
   input  logic              pol_sel,
   input  logic [1:0]        len_c,
   input  logic [HALF_W-1:0] hidx,
   output logic [NDRV-1:0]   sel_o
);
   localparam int HW = 2 * WORD_W;

   logic [NDRV-1:0] act;
   int              len_i;
   int              h_i;
   int              end_all;

   assign len_i   = int'(len_c);
   assign h_i     = int'(hidx);
   assign end_all = HW * (len_i + 1) + 1;

   for (genvar k = 0; k < NDRV; k++) begin : g_sel
      logic ind_a;
      logic com_a;
      if (k == 0) begin : g_first
         assign com_a = busy && (h_i < end_all);
         assign ind_a = busy && (h_i >= HW * len_i) && (h_i < end_all);
      end else begin : g_rest
         assign com_a = 1'b0;
         assign ind_a = busy && (k <= len_i) && (h_i >= HW * (len_i - k))
                        && (h_i < HW * (len_i - k + 1));
      end
      assign act[k]   = indiv ? ind_a : com_a;
      assign sel_o[k] = pol_sel ? act[k] : ~act[k];
   end

   // R11
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act));

   // R12
   sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> act == '0);
endmodule

// File: rtl/stepchain_master.sv
module stepchain_master
   import stepchain_pkg::*;
#(
   parameter int NDRV    = 3,
   parameter int DIV_MIN = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [1:0]             cfg_len,
   input  logic [6:0]             cfg_div,
   input  logic                   cfg_pol_sel,
   input  logic                   cfg_pol_sck,
   input  logic                   cfg_pol_ph,
   input  logic                   cfg_pol_fd,
   input  logic                   cfg_pol_dac,
   input  logic                   cfg_indiv,
   input  logic                   start,
   input  logic [NDRV*WORD_W-1:0] drv_words,
   output logic                   busy,
   output logic [NDRV-1:0]        sel_o,
   output logic                   sck_o,
   output logic                   sdo_o
);
   if (NDRV < 1 || NDRV > 3) begin : g_bad_ndrv
      $error("NDRV must be 1 to 3");
   end

   localparam int TOT    = NDRV * WORD_W;
   localparam int HALF_W = $clog2(2 * TOT + 3);

   chain_cfg_t        cfg_q;
   logic [1:0]        len_c;
   logic [HALF_W-1:0] hidx;
   logic [TOT-1:0]    sreg;
   logic [TOT-1:0]    frame_bits;
   logic              tick;
   logic              start_ok;
   logic              sck_raw;
   int                nb2;
   int                last_h;

   assign start_ok = start && !busy;
   assign len_c    = (cfg_q.len > 2'(NDRV - 1)) ? 2'(NDRV - 1) : cfg_q.len;
   assign nb2      = 2 * WORD_W * (int'(len_c) + 1);
   assign last_h   = nb2 + 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '{len: '0, div: '1, pol_sel: 1'b0, pol_sck: 1'b0,
                    pol_ph: 1'b0, pol_fd: 1'b0, pol_dac: 1'b0, indiv: 1'b0};
      end else if (cfg_we && !busy) begin
         cfg_q <= '{len: cfg_len, div: cfg_div, pol_sel: cfg_pol_sel,
                    pol_sck: cfg_pol_sck, pol_ph: cfg_pol_ph, pol_fd: cfg_pol_fd,
                    pol_dac: cfg_pol_dac, indiv: cfg_indiv};
      end
   end

   stepchain_divider #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) div_i (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_q.div), .tick(tick));

   stepchain_fmt #(.NDRV(NDRV)) fmt_i (
      .words(drv_words), .len_c(len_c), .pol_ph(cfg_q.pol_ph),
      .pol_fd(cfg_q.pol_fd), .pol_dac(cfg_q.pol_dac), .frame_bits(frame_bits));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         hidx <= '0;
      end else if (start_ok) begin
         busy <= 1'b1;
         hidx <= '0;
      end else if (busy && tick) begin
         if (int'(hidx) == last_h) busy <= 1'b0;
         else                      hidx <= hidx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg <= '0;
      else if (start_ok)
         sreg <= frame_bits;
      else if (busy && tick && hidx[0] && int'(hidx) < nb2 - 1)
         sreg <= sreg << 1;
   end

   assign sck_raw = busy && hidx[0] && (int'(hidx) < nb2);
   assign sck_o   = sck_raw ^ cfg_q.pol_sck;
   assign sdo_o   = busy & sreg[TOT-1];

   stepchain_selgen #(.NDRV(NDRV), .HALF_W(HALF_W)) sel_i (
      .clk(clk), .rst_n(rst_n), .busy(busy), .indiv(cfg_q.indiv),
      .pol_sel(cfg_q.pol_sel), .len_c(len_c), .hidx(hidx), .sel_o(sel_o));

   // R12
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> busy);

   // R5
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_o == cfg_q.pol_sck);

   // R9
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_raw && $past(sck_raw) && $past(busy)) |-> $stable(sdo_o));

   // R13
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cfg_q));
endmodule

// File: tb/stepchain_master_tb.sv
module stepchain_master_tb_top;
   localparam int NDRV = 3;
   localparam int W    = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_len = '0;
   logic [6:0]      cfg_div = '0;
   logic            cfg_pol_sel = 1'b0, cfg_pol_sck = 1'b0, cfg_pol_ph = 1'b0;
   logic            cfg_pol_fd = 1'b0, cfg_pol_dac = 1'b0, cfg_indiv = 1'b0;
   logic            start = 1'b0;
   logic [NDRV*W-1:0] drv_words = '0;
   logic            busy;
   logic [NDRV-1:0] sel_o;
   logic            sck_o;
   logic            sdo_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   stepchain_master #(.NDRV(NDRV)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
      .cfg_div(cfg_div), .cfg_pol_sel(cfg_pol_sel), .cfg_pol_sck(cfg_pol_sck),
      .cfg_pol_ph(cfg_pol_ph), .cfg_pol_fd(cfg_pol_fd), .cfg_pol_dac(cfg_pol_dac),
      .cfg_indiv(cfg_indiv), .start(start), .drv_words(drv_words),
      .busy(busy), .sel_o(sel_o), .sck_o(sck_o), .sdo_o(sdo_o));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected settings of the frame to come
   int         e_len, e_div;
   logic [4:0] e_pol;   // {sel, sck, ph, fd, dac}
   bit         e_ind;

   task automatic load_cfg(input int len, input int dv, input logic [4:0] pol, input bit ind);
      @(negedge clk);
      cfg_len = 2'(len); cfg_div = 7'(dv);
      {cfg_pol_sel, cfg_pol_sck, cfg_pol_ph, cfg_pol_fd, cfg_pol_dac} = pol;
      cfg_indiv = ind; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      e_len = len; e_div = dv; e_pol = pol; e_ind = ind;
   endtask

   task automatic run_frame(input bit disturb);
      int         le, n, h;
      logic [35:0] exp_s, got_s, m_ph, m_fd, m_dac, diff;
      int         bcnt, hi_first, hi_run, rises, scnt [NDRV], exp_sc;
      bit         prev, sl, in_first;
      logic       act_lvl;
      le = (e_len > 2) ? 2 : e_len;
      n  = W * (le + 1);
      h  = ((e_div < 7) ? 7 : e_div) + 1;
      act_lvl = e_pol[4];
      exp_s = '0; m_ph = '0; m_fd = '0; m_dac = '0;
      for (int i = 0; i < NDRV; i++) drv_words[i*W +: W] = 12'($urandom);
      for (int j = 0; j <= le; j++) begin
         logic [11:0] w;
         w = drv_words[(le - j)*W +: W];
         w[11] ^= e_pol[2]; w[5] ^= e_pol[2];
         w[10] ^= e_pol[1]; w[4] ^= e_pol[1];
         w[9:6] ^= {4{e_pol[0]}}; w[3:0] ^= {4{e_pol[0]}};
         exp_s = {exp_s[23:0], w};
         m_ph  = {m_ph[23:0], 12'h820};
         m_fd  = {m_fd[23:0], 12'h410};
         m_dac = {m_dac[23:0], 12'h3CF};
      end
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R12 busy rise", busy, 1);
      bcnt = 0; rises = 0; got_s = '0; prev = 1'b0; hi_first = 0; hi_run = 0;
      in_first = 1'b1;
      for (int k = 0; k < NDRV; k++) scnt[k] = 0;
      while (busy === 1'b1 && bcnt < 4000) begin
         bcnt++;
         sl = sck_o ^ e_pol[3];
         if (sl && !prev) begin
            rises++;
            got_s = {got_s[34:0], sdo_o};
         end
         if (sl) hi_run++;
         if (!sl && prev && in_first) begin hi_first = hi_run; in_first = 1'b0; end
         prev = sl;
         for (int k = 0; k < NDRV; k++) if (sel_o[k] === act_lvl) scnt[k]++;
         if (disturb && bcnt == 40) begin
            cfg_div = 7'd20; cfg_we = 1'b1; start = 1'b1;
         end else if (disturb && bcnt == 41) begin
            cfg_we = 1'b0; start = 1'b0;
         end
         @(negedge clk);
      end
      // R1
      check(rises == n, "R1 bit count", rises, n);
      // R12 and R3
      check(bcnt == (2*n + 3) * h, e_div < 7 ? "R3 frame length" : "R12 frame length",
            bcnt, (2*n + 3) * h);
      // R2
      check(hi_first == h, "R2 clock high time", hi_first, h);
      diff = got_s ^ exp_s;
      check((diff & m_ph) == 0, "R6 phase bits", got_s, exp_s);
      check((diff & m_fd) == 0, "R7 fast-decay bits", got_s, exp_s);
      check((diff & m_dac) == 0, "R8 DAC bits", got_s, exp_s);
      check(diff == 0, "R9 order", got_s, exp_s);
      for (int k = 0; k < NDRV; k++) begin
         if (!e_ind) exp_sc = (k == 0) ? (2*n + 1) * h : 0;
         else if (k > le) exp_sc = 0;
         else exp_sc = (k == 0) ? 25 * h : 24 * h;
         check(scnt[k] == exp_sc, e_ind ? "R11 select window" : "R10 select window",
               scnt[k], exp_sc);
      end
      // R4, R5 idle levels
      check(sel_o === {NDRV{~act_lvl}}, "R4 idle select", sel_o, {NDRV{~act_lvl}});
      check(sck_o === e_pol[3], "R5 idle clock", sck_o, e_pol[3]);
      if (disturb) begin
         @(negedge clk);
         check(busy === 1'b0, "R12 start ignored", busy, 0);
      end
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 190000) begin
            n_fail++;
            $display("FAIL R12 watchdog expired actual=%0d expected<190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin : main
      logic [4:0] pols [4];
      int         dvs [4];
      pols[0] = 5'b00000; pols[1] = 5'b11111; pols[2] = 5'b10101; pols[3] = 5'b01010;
      dvs[0] = 0; dvs[1] = 7; dvs[2] = 3; dvs[3] = 9;
      repeat (3) @(negedge clk);
      // reset state: R4 and R5 defaults
      check(busy === 1'b0, "R12 reset busy", busy, 0);
      check(sel_o === '1, "R4 reset select", sel_o, 3'b111);
      check(sck_o === 1'b0, "R5 reset clock", sck_o, 0);
      rst_n = 1'b1;
      for (int len = 0; len < 4; len++)
         for (int ind = 0; ind < 2; ind++)
            for (int p = 0; p < 4; p++) begin
               load_cfg(len, dvs[p], pols[p], ind[0]);
               run_frame(1'b0);
            end
      // R13: write mid-frame is dropped; next frame keeps div 12
      load_cfg(2, 12, 5'b10010, 1'b1);
      run_frame(1'b1);
      run_frame(1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule